// File: doc/BRIEF.md
# Extended Match Channel Array

This block adds eight match channels to a system timer. Internally they are numbered 0 to 7, and they appear to software as channels 4 to 11. Each channel has three registers: a 32-bit counter, a 32-bit match value and a control word. The control word selects which of five incoming tick strobes advances the counter. It also decides whether the counter clears when a match occurs, whether matching repeats or fires only once, and whether the channel compares against its own counter or against the counter of its group leader.

A match sets the channel's status bit, but only when the matching enable bit from the base timer is high. All eight status bits drive one shared interrupt line. The base timer clears status bits with a one-cycle clear mask. Two channels can be set so that reading their own counter also copies their partner's counter into a snapshot register. Software can then read a consistent pair of values.

Register access is a simple single-cycle bus. Writes take effect on the clock edge. Read data is combinational from the address. The read strobe is used only to trigger a snapshot.

Top module: `match_chan_array`

## Requirements
- R1: Channel index n (0 to 7) has its counter at byte address 0x40+4n, its match value at 0x80+4n and its control word at 0xC0+4n. The snapshot register is at 0x20. After reset every register reads 0, status_o is 0 and irq_o is low.
- R2: Control bits [2:0] select the rate. Code 1 counts on tick_i[0], code 2 on tick_i[1], code 3 on tick_i[2], code 4 on tick_i[3] and code 5 on tick_i[4]. The counter advances by one per selected strobe and wraps from 0xFFFFFFFF to 0.
- R3: Rate codes 0, 6 and 7 stop the counter, which then holds its value. On indices 4 to 7, control bit 8 set also stops the counter, whatever the rate code.
- R4: A control write keeps bits [7:0] on indices 0 to 3 and bits [9:0] on indices 4 to 7. All other bits read back as 0.
- R5: A channel hits when its source counter steps onto the match value. A hit sets status_o[n] only if irq_en_i[n] is high.
- R6: With control bit 3 set, a hit on a channel counting its own counter loads that counter with 0 instead of the match value.
- R7: With control bit 6 clear, a channel hits at most once. Any write to its counter, match or control register arms it again. With bit 6 set, it hits every time the counter steps onto the match value.
- R8: Indices 0, 4 and 6 always count their own counter. The other indices count their own counter only when control bit 7 is set. When bit 7 is clear, they compare against the counter of their leader (index 0 for indices 1 to 3, index 4 for index 5, index 6 for index 7), and their own counter holds.
- R9: A read strobe at the counter address of index 5 or index 7, with that index's control bit 9 set, copies the counter of index 4 or index 6 into the snapshot register. Without bit 9 set, the snapshot register is left unchanged.
- R10: A high bit of sts_clr_i clears that status bit on the next edge. irq_o is high exactly while any status bit is set.
- R11: A counter write loads the written value on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (triggers snapshot) |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| tick_i | input | 5 | Rate strobes: 32.768 kHz, 1 kHz, 1 Hz, 1 MHz, external |
| irq_en_i | input | 8 | Status enables for channels 4 to 11, from the base timer |
| sts_clr_i | input | 8 | Status clear mask from the base timer |
| status_o | output | 8 | Status bits for channels 4 to 11 |
| irq_o | output | 1 | Shared interrupt |

## Verification
If a channel picks the wrong rate strobe or decodes the stop conditions wrongly, its counter drifts away from the strobe count. The drift appears at the counter address one edge after the strobe. A wrongly armed channel, or a missed clear of the counter, shows on status_o in the cycle after the step onto the match value, or one step later as a counter value that is off by the match value. The same happens when a follower compares against the wrong counter. A wrong snapshot partner shows at 0x20 on the first read after the triggering counter read.

// File: rtl/mca_pkg.sv
package mca_pkg;
  localparam int unsigned NCH   = 8;
  localparam int unsigned CW    = 32;
  localparam int unsigned NTICK = 5;
  localparam int unsigned CTLW  = 10;

  typedef enum logic [2:0] {
    RATE_OFF0 = 3'd0,
    RATE_32K  = 3'd1,
    RATE_1K   = 3'd2,
    RATE_1HZ  = 3'd3,
    RATE_1M   = 3'd4,
    RATE_EXT  = 3'd5,
    RATE_OFF6 = 3'd6,
    RATE_OFF7 = 3'd7
  } rate_e;

  function automatic int unsigned leader_of(input int unsigned n);
    if (n < 4) return 0;
    else if (n < 6) return 4;
    else return 6;
  endfunction

  function automatic logic tick_pick(input logic [2:0] code, input logic [NTICK-1:0] ticks);
    case (rate_e'(code))
      RATE_32K: return ticks[0];
      RATE_1K:  return ticks[1];
      RATE_1HZ: return ticks[2];
      RATE_1M:  return ticks[3];
      RATE_EXT: return ticks[4];
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/mca_channel.sv
module mca_channel
  import mca_pkg::*;
#(
  parameter bit LEADER = 1'b0,
  parameter bit WIDE   = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_we_i,
  input  logic             match_we_i,
  input  logic             ctrl_we_i,
  input  logic [CW-1:0]    wdata_i,
  input  logic [NTICK-1:0] tick_i,
  input  logic             grp_adv_i,
  input  logic [CW-1:0]    grp_inc_i,
  output logic [CW-1:0]    cnt_o,
  output logic [CW-1:0]    match_o,
  output logic [CTLW-1:0]  ctrl_o,
  output logic             adv_o,
  output logic [CW-1:0]    inc_o,
  output logic             hit_o
);
  logic [CW-1:0]   cnt_q, match_q;
  logic [CTLW-1:0] ctrl_q;
  logic            armed_q;
  logic            own_src, stop_forced, tick;
  logic [2:0]      rate;
  logic            src_adv;
  logic [CW-1:0]   src_inc;
  logic            any_we;

  assign own_src     = LEADER || ctrl_q[7];
  assign stop_forced = WIDE && ctrl_q[8];
  assign rate        = stop_forced ? 3'd0 : ctrl_q[2:0];
  assign tick        = own_src && tick_pick(rate, tick_i);
  assign adv_o       = tick && !cnt_we_i;
  assign inc_o       = cnt_q + 1'b1;
  assign src_adv     = own_src ? adv_o : grp_adv_i;
  assign src_inc     = own_src ? inc_o : grp_inc_i;
  assign hit_o       = armed_q && src_adv && (src_inc == match_q);
  assign any_we      = cnt_we_i || match_we_i || ctrl_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      match_q <= '0;
      ctrl_q  <= '0;
      armed_q <= 1'b1;
    end else begin
      if (cnt_we_i)                          cnt_q <= wdata_i;
      else if (hit_o && ctrl_q[3] && own_src) cnt_q <= '0;
      else if (adv_o)                        cnt_q <= inc_o;

      if (match_we_i) match_q <= wdata_i;

      if (ctrl_we_i) begin
        if (WIDE) ctrl_q <= wdata_i[CTLW-1:0];
        else      ctrl_q <= {2'b00, wdata_i[7:0]};
      end

      if (any_we)                      armed_q <= 1'b1;
      else if (hit_o && !ctrl_q[6])    armed_q <= 1'b0;
    end
  end

  assign cnt_o   = cnt_q;
  assign match_o = match_q;
  assign ctrl_o  = ctrl_q;

  assert_cnt_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> cnt_o == $past(wdata_i));

  assert_stopped_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_we_i && !tick && !hit_o) |=> $stable(cnt_o));

  assert_one_shot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !ctrl_o[6] && !any_we) |=> !hit_o);

  assert_narrow_ctrl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !WIDE |-> ctrl_o[9:8] == 2'b00);
endmodule

// File: rtl/mca_status.sv
module mca_status
  import mca_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] status_o,
  output logic           irq_o
);
  logic [NCH-1:0] sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (sts_q & ~clr_i) | set_i;
  end

  assign status_o = sts_q;
  assign irq_o    = |sts_q;

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_set_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status_o[i]) |-> $past(set_i[i]));
    assert_clr_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(status_o[i]) |-> $past(clr_i[i]));
  end
endmodule

// File: rtl/match_chan_array.sv
module match_chan_array
  import mca_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [7:0]       addr_i,
  input  logic [CW-1:0]    wdata_i,
  output logic [CW-1:0]    rdata_o,
  input  logic [NTICK-1:0] tick_i,
  input  logic [NCH-1:0]   irq_en_i,
  input  logic [NCH-1:0]   sts_clr_i,
  output logic [NCH-1:0]   status_o,
  output logic             irq_o
);
  localparam logic [2:0] SEG_CNT   = 3'b010;
  localparam logic [2:0] SEG_MATCH = 3'b100;
  localparam logic [2:0] SEG_CTRL  = 3'b110;
  localparam logic [7:0] SNAP_ADDR = 8'h20;

  logic [CW-1:0]   cnt   [NCH];
  logic [CW-1:0]   mtch  [NCH];
  logic [CTLW-1:0] ctrl  [NCH];
  logic [CW-1:0]   inc   [NCH];
  logic [NCH-1:0]  adv, hit;
  logic [NCH-1:0]  cnt_sel, match_sel, ctrl_sel;
  logic [2:0]      idx;
  logic [2:0]      seg;
  logic            aligned;
  logic [CW-1:0]   snap_q;

  assign idx     = addr_i[4:2];
  assign seg     = addr_i[7:5];
  assign aligned = (addr_i[1:0] == 2'b00);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int unsigned LD = leader_of(g);
    assign cnt_sel[g]   = aligned && seg == SEG_CNT   && idx == 3'(g);
    assign match_sel[g] = aligned && seg == SEG_MATCH && idx == 3'(g);
    assign ctrl_sel[g]  = aligned && seg == SEG_CTRL  && idx == 3'(g);

    mca_channel #(
      .LEADER(LD == g),
      .WIDE  (g >= 4)
    ) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cnt_we_i  (wr_en_i && cnt_sel[g]),
      .match_we_i(wr_en_i && match_sel[g]),
      .ctrl_we_i (wr_en_i && ctrl_sel[g]),
      .wdata_i   (wdata_i),
      .tick_i    (tick_i),
      .grp_adv_i (adv[LD]),
      .grp_inc_i (inc[LD]),
      .cnt_o     (cnt[g]),
      .match_o   (mtch[g]),
      .ctrl_o    (ctrl[g]),
      .adv_o     (adv[g]),
      .inc_o     (inc[g]),
      .hit_o     (hit[g])
    );
  end

  // snapshot: index 5 grabs index 4, index 7 grabs index 6
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) snap_q <= '0;
    else if (rd_en_i && cnt_sel[5] && ctrl[5][9]) snap_q <= cnt[4];
    else if (rd_en_i && cnt_sel[7] && ctrl[7][9]) snap_q <= cnt[6];
  end

  always_comb begin
    rdata_o = '0;
    if (aligned && addr_i == SNAP_ADDR) rdata_o = snap_q;
    else if (aligned) begin
      case (seg)
        SEG_CNT:   rdata_o = cnt[idx];
        SEG_MATCH: rdata_o = mtch[idx];
        SEG_CTRL:  rdata_o = CW'(ctrl[idx]);
        default:   rdata_o = '0;
      endcase
    end
  end

  mca_status u_sts (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (hit & irq_en_i),
    .clr_i   (sts_clr_i),
    .status_o(status_o),
    .irq_o   (irq_o)
  );

  assert_snap_9_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 8'h54 && ctrl[5][9]) |=> snap_q == $past(cnt[4]));

  assert_snap_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(snap_q));

  assert_follower_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl[1][7] && !(wr_en_i && cnt_sel[1])) |=> $stable(cnt[1]));
endmodule

// File: tb/sim_match_chan_array.sv
module sim_match_chan_array;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [4:0]  tick = '0;
  logic [7:0]  irq_en = '0, sts_clr = '0;
  logic [7:0]  status;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  match_chan_array u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick),
    .irq_en_i(irq_en), .sts_clr_i(sts_clr), .status_o(status), .irq_o(irq)
  );

  function automatic logic counts(input logic [9:0] c, input bit wide, input logic [4:0] m);
    logic [2:0] r;
    r = (wide && c[8]) ? 3'd0 : c[2:0];
    if (r >= 3'd1 && r <= 3'd5) return m[r-1];
    return 1'b0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input bit strobe, output logic [31:0] d);
    addr = a; rd_en = strobe;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [4:0] m, input int times);
    for (int i = 0; i < times; i++) begin
      tick = m;
      @(negedge clk);
      tick = '0;
    end
  endtask

  task automatic clr(input logic [7:0] m);
    sts_clr = m;
    @(negedge clk);
    sts_clr = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] exp_cnt;
    logic [9:0]  c;
    logic [4:0]  m;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'hC0, 0, d); chk("R1 ctrl reset", d, 0);
    rd(8'h40, 0, d); chk("R1 cnt reset", d, 0);
    rd(8'h20, 0, d); chk("R1 snap reset", d, 0);
    chk("R1 irq reset", {23'd0, irq, status}, 0);

    // R2 rate select
    wr(8'hC0, 32'h1);
    pulse(5'b00001, 5);
    pulse(5'b00010, 3);
    rd(8'h40, 0, d); chk("R2 32k count", d, 5);

    // R3 stop codes
    wr(8'hC4, 32'h86); wr(8'h44, 100);
    pulse(5'b11111, 4);
    rd(8'h44, 0, d); chk("R3 code 6 holds", d, 100);
    wr(8'hD0, 32'h104); wr(8'h50, 7);
    pulse(5'b01000, 3);
    rd(8'h50, 0, d); chk("R3 bit8 forces stop", d, 7);

    // R4 control width
    wr(8'hC8, 32'hFFFF_FFFF); rd(8'hC8, 0, d); chk("R4 narrow ctrl", d, 32'hFF);
    wr(8'hD8, 32'hFFFF_FFFF); rd(8'hD8, 0, d); chk("R4 wide ctrl", d, 32'h3FF);
    wr(8'hC8, 0); wr(8'hD8, 0);

    // R5 match sets status, R10 clear
    irq_en = 8'h01;
    wr(8'hC0, 32'h01); wr(8'h40, 0); wr(8'h80, 3);
    pulse(5'b00001, 3);
    chk("R5 status set", {23'd0, irq, status}, {23'd0, 1'b1, 8'h01});
    clr(8'h01);
    chk("R10 cleared", {23'd0, irq, status}, 0);

    // R5 enable gating
    irq_en = 8'h00;
    wr(8'h40, 0);
    pulse(5'b00001, 3);
    chk("R5 enable gates", {24'd0, status}, 0);

    // R6 clear on match, R7 one-shot
    irq_en = 8'h01;
    wr(8'hC0, 32'h09); wr(8'h80, 2); wr(8'h40, 0);
    pulse(5'b00001, 2);
    chk("R5 hit with clear", {24'd0, status}, 8'h01);
    rd(8'h40, 0, d); chk("R6 counter cleared", d, 0);
    clr(8'h01);
    pulse(5'b00001, 2);
    chk("R7 one-shot no rehit", {24'd0, status}, 0);
    rd(8'h40, 0, d); chk("R7 one-shot counts on", d, 2);

    // R7 periodic
    wr(8'hC0, 32'h49); wr(8'h40, 0);
    pulse(5'b00001, 2);
    clr(8'h01);
    pulse(5'b00001, 2);
    chk("R7 periodic rehit", {24'd0, status}, 8'h01);
    clr(8'h01);

    // R8 shared counter
    irq_en = 8'h04;
    wr(8'hC0, 32'h01); wr(8'h80, 32'hFFFF); wr(8'h40, 0);
    wr(8'hC8, 32'h01); wr(8'h88, 5);
    pulse(5'b00001, 5);
    chk("R8 follower matched leader", {24'd0, status}, 8'h04);
    rd(8'h48, 0, d); chk("R8 follower own frozen", d, 0);

    // R10 shared irq with two sources
    irq_en = 8'h05;
    wr(8'h80, 7);
    pulse(5'b00001, 2);
    chk("R10 two bits", {24'd0, status}, 8'h05);
    clr(8'h04);
    chk("R10 irq held", {31'd0, irq}, 1);
    clr(8'h01);
    chk("R10 irq dropped", {31'd0, irq}, 0);
    irq_en = 8'h00;

    // R9 snapshot
    wr(8'hD0, 32'h01); wr(8'h50, 32'h1234);
    pulse(5'b00001, 1);
    wr(8'hD4, 32'h200);
    rd(8'h54, 1, d);
    rd(8'h20, 0, d); chk("R9 snapshot of index4", d, 32'h1235);
    wr(8'hD8, 32'h0); wr(8'h58, 32'h99); wr(8'hDC, 32'h0);
    rd(8'h5C, 1, d);
    rd(8'h20, 0, d); chk("R9 no snapshot without bit9", d, 32'h1235);

    // R2 wrap, R11 load
    wr(8'hD8, 32'h04); wr(8'h58, 32'hFFFF_FFFF);
    rd(8'h58, 0, d); chk("R11 load", d, 32'hFFFF_FFFF);
    pulse(5'b01000, 1);
    rd(8'h58, 0, d); chk("R2 wrap", d, 0);

    // R2 external strobe on own-counting follower
    wr(8'hDC, 32'h85); wr(8'h5C, 0);
    pulse(5'b10000, 2);
    rd(8'h5C, 0, d); chk("R2 external rate", d, 2);

    // random: leader index 4, random control and strobes
    for (int it = 0; it < 40; it++) begin
      c = 10'($urandom) & 10'h107;
      exp_cnt = $urandom;
      wr(8'hD0, {22'd0, c});
      wr(8'h50, exp_cnt);
      for (int k = 0; k < 10; k++) begin
        m = 5'($urandom);
        if (counts(c, 1'b1, m)) exp_cnt = exp_cnt + 1;
        pulse(m, 1);
      end
      rd(8'h50, 0, d); chk("R2 R3 random rate", d, exp_cnt);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule